// File: doc/BRIEF.md
# Memory Client Hot-Reset Flush Controller

This controller quiets the memory clients that belong to one power partition before that partition loses power, and lets them go again afterwards. A requester pulses `req_valid` with a partition number and an operation kind. The operation is either a drain (flush) or a release. The block looks up that partition's client list in a table fixed by a parameter. It then works on the hot-reset control word that it drives towards the memory controller.

A drain handles clients strictly one after another. For each client, the block raises that client's bit in the control word and leaves every other bit as it is. It then waits a programmable poll interval and reads the status word repeatedly. A reading counts only when it stays identical across a run of further reads and shows the client's bit set. Only then does the block move on to the next client. A release clears the listed bits in list order and never waits for status. When either operation is finished, `ack` pulses for one cycle.

States: `ST_IDLE` waits for a request. `ST_FETCH` looks at the current list entry: it ends the list, raises a bit, or clears a bit. `ST_GAP` runs the poll interval timer. `ST_SAMPLE` runs the stability check on the status word. `ST_DONE` drives the acknowledge. The transitions are:
- IDLE→FETCH when a request arrives.
- FETCH→DONE when the list ends.
- FETCH→GAP after a drain raises a bit.
- FETCH→FETCH after a release clears a bit.
- GAP→SAMPLE when the interval expires.
- SAMPLE→FETCH when the client is confirmed.
- SAMPLE→GAP when the reading is unstable or the client's bit is clear.
- DONE→IDLE.

Top module: `mc_flush_ctrl`

## Requirements
- R1: After reset, `hr_ctrl` is all zeros and `ack` is low.
- R2: A drain raises the listed clients' bits in list order, one bit at a time, and keeps all other control bits. After its acknowledge, every listed bit is set.
- R3: During a drain, the next client's bit is not raised until the current client's status bit has been confirmed.
- R4: A status reading is accepted only when `DEBOUNCE` further consecutive reads equal it. If any read differs, the reading is discarded and polling resumes after another interval.
- R5: Before each status reading, the block waits `POLL_DELAY` cycles, both after raising a bit and after a rejected reading. With status already confirming, a single-client drain acknowledges `POLL_DELAY+DEBOUNCE+4` cycles after the request edge, counted at falling edges.
- R6: A partition whose first list entry is the terminator acknowledges within 3 cycles and leaves `hr_ctrl` unchanged.
- R7: A release clears each listed client's bit in list order without looking at status, keeps the other bits, and acknowledges within `MAX_CLIENTS+3` cycles.
- R8: `ack` is high for exactly one cycle per completed operation.
- R9: A request that arrives while an operation is in progress is ignored. It changes no control bit and produces no second acknowledge.
- R10: `hr_ctrl` does not change while the block is idle.
- R11: The client table holds 8-bit entries. Entry `s` of partition `p` sits at bits `[(p*MAX_CLIENTS+s)*8 +: 8]`. The value 8'hFF, any value of at least `CTRL_W`, or reaching slot `MAX_CLIENTS` ends the list. In the default table, partition 0 lists bits 8 then 17, partition 1 lists 5 then 4, partition 2 is empty, and partition 3 lists bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_flush | input | 1 | 1 = drain the partition's clients, 0 = release them |
| req_part | input | PART_W | Partition number |
| ack | output | 1 | One-cycle completion pulse |
| hr_ctrl | output | CTRL_W | Hot-reset control word, one bit per client |
| hr_stat | input | CTRL_W | Hot-reset status word from the memory controller |

## Verification
The hardest situation to reach from the ports is a status word that shows the wanted client bit but never holds still long enough to be accepted. In that case the block must keep cycling between interval and sampling without advancing. The bench builds the status word from the control word. It adds a hold mask that keeps chosen bits low and a toggling bit at a position no client uses. This lets it stall a drain on one client to check ordering, and force endless rejections with the glitch. It then removes either obstacle and watches the drain finish. The same stall window is used to inject a competing request while the block is busy.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_GAP,
        ST_SAMPLE,
        ST_DONE
    } mcf_state_e;

    localparam logic [7:0] LIST_END = 8'hFF;
endpackage

// File: rtl/mcf_client_lut.sv
module mcf_client_lut #(
    parameter int NUM_PART    = 4,
    parameter int MAX_CLIENTS = 4,
    parameter int CTRL_W      = 32,
    parameter logic [NUM_PART*MAX_CLIENTS*8-1:0] TABLE = '1,
    localparam int PART_W = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
    localparam int SLOT_W = $clog2(MAX_CLIENTS + 1),
    localparam int IDX_W  = $clog2(CTRL_W)
) (
    input  logic [PART_W-1:0] part,
    input  logic [SLOT_W-1:0] slot,
    output logic [IDX_W-1:0]  client,
    output logic              is_end
);
    logic [7:0] entry;

    always_comb begin
        int pos;
        pos   = int'(part) * MAX_CLIENTS + int'(slot);
        entry = mcf_pkg::LIST_END;
        if (int'(slot) < MAX_CLIENTS && int'(part) < NUM_PART) begin
            entry = TABLE[pos*8 +: 8];
        end
        is_end = (entry == mcf_pkg::LIST_END) || (int'(entry) >= CTRL_W);
        client = entry[IDX_W-1:0];
    end
endmodule

// File: rtl/mcf_gap_timer.sv
module mcf_gap_timer #(
    parameter int DELAY = 1000,
    localparam int DLY_W = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic fire
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= DLY_W'(DELAY);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign fire = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/mcf_stable_sampler.sv
module mcf_stable_sampler #(
    parameter int W        = 32,
    parameter int DEBOUNCE = 5,
    localparam int DB_W = $clog2(DEBOUNCE + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] stat,
    output logic         done,
    output logic         ok,
    output logic [W-1:0] value
);
    logic            busy_q;
    logic [W-1:0]    ref_q;
    logic [DB_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ref_q  <= '0;
            cnt_q  <= '0;
            done   <= 1'b0;
            ok     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                ref_q  <= stat;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (stat != ref_q) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                    ok     <= 1'b0;
                end else if (cnt_q == DB_W'(DEBOUNCE - 1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                    ok     <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign value = ref_q;
endmodule

// File: rtl/mc_flush_ctrl.sv
module mc_flush_ctrl #(
    parameter int NUM_PART    = 4,
    parameter int MAX_CLIENTS = 4,
    parameter int CTRL_W      = 32,
    parameter int POLL_DELAY  = 1000,
    parameter int DEBOUNCE    = 5,
    parameter logic [NUM_PART*MAX_CLIENTS*8-1:0] CLIENT_TABLE = {
        8'hFF, 8'hFF, 8'hFF, 8'd12,
        8'hFF, 8'hFF, 8'hFF, 8'hFF,
        8'hFF, 8'hFF, 8'd4,  8'd5,
        8'hFF, 8'hFF, 8'd17, 8'd8
    },
    localparam int PART_W = (NUM_PART > 1) ? $clog2(NUM_PART) : 1,
    localparam int SLOT_W = $clog2(MAX_CLIENTS + 1),
    localparam int IDX_W  = $clog2(CTRL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_flush,
    input  logic [PART_W-1:0] req_part,
    output logic              ack,
    output logic [CTRL_W-1:0] hr_ctrl,
    input  logic [CTRL_W-1:0] hr_stat
);
    import mcf_pkg::*;

    mcf_state_e        state, state_nx;
    logic              op_flush;
    logic [PART_W-1:0] op_part;
    logic [SLOT_W-1:0] slot;
    logic [CTRL_W-1:0] ctrl_q;

    logic [IDX_W-1:0]  client;
    logic              is_end;
    logic              tmr_load, tmr_fire;
    logic              smp_start, smp_done, smp_ok;
    logic [CTRL_W-1:0] smp_val;
    logic              accepted;

    mcf_client_lut #(
        .NUM_PART(NUM_PART), .MAX_CLIENTS(MAX_CLIENTS),
        .CTRL_W(CTRL_W), .TABLE(CLIENT_TABLE)
    ) u_lut (
        .part(op_part), .slot(slot), .client(client), .is_end(is_end)
    );

    mcf_gap_timer #(.DELAY(POLL_DELAY)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .fire(tmr_fire)
    );

    mcf_stable_sampler #(.W(CTRL_W), .DEBOUNCE(DEBOUNCE)) u_smp (
        .clk(clk), .rst_n(rst_n), .start(smp_start), .stat(hr_stat),
        .done(smp_done), .ok(smp_ok), .value(smp_val)
    );

    assign accepted  = smp_done && smp_ok && smp_val[client];
    assign smp_start = (state == ST_GAP) && tmr_fire;
    assign tmr_load  = ((state == ST_FETCH) && !is_end && op_flush) ||
                       ((state == ST_SAMPLE) && smp_done && !accepted);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_FETCH;
            ST_FETCH:  if (is_end) state_nx = ST_DONE;
                       else if (op_flush) state_nx = ST_GAP;
            ST_GAP:    if (tmr_fire) state_nx = ST_SAMPLE;
            ST_SAMPLE: if (smp_done) state_nx = accepted ? ST_FETCH : ST_GAP;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_flush <= 1'b0;
            op_part  <= '0;
            slot     <= '0;
            ctrl_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    op_flush <= req_flush;
                    op_part  <= req_part;
                    slot     <= '0;
                end
                ST_FETCH: if (!is_end) begin
                    if (op_flush) begin
                        ctrl_q[client] <= 1'b1;
                    end else begin
                        ctrl_q[client] <= 1'b0;
                        slot           <= slot + 1'b1;
                    end
                end
                ST_SAMPLE: if (accepted) slot <= slot + 1'b1;
                default: ;
            endcase
        end
    end

    assign hr_ctrl = ctrl_q;
    assign ack     = (state == ST_DONE);
endmodule

// File: rtl/mcf_checker.sv
module mcf_checker #(
    parameter int CTRL_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack,
    input logic [CTRL_W-1:0]  hr_ctrl,
    input mcf_pkg::mcf_state_e state,
    input logic               smp_done,
    input logic               smp_ok
);
    import mcf_pkg::*;

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_after_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(state) == ST_FETCH);

    assert_one_bit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hr_ctrl ^ $past(hr_ctrl)) <= 1);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(hr_ctrl));

    assert_reject_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE && smp_done && !smp_ok) |=> state == ST_GAP);
endmodule

bind mc_flush_ctrl mcf_checker #(.CTRL_W(CTRL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .hr_ctrl(hr_ctrl),
    .state(state), .smp_done(smp_done), .smp_ok(smp_ok)
);

// File: tb/mc_flush_ctrl_tb.sv
module mc_flush_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int D   = 16;
    localparam int DB  = 5;
    localparam int MAXC = 4;
    localparam int W   = 32;
    localparam int NV  = 7;

    // {flush, part[1:0], expected hr_ctrl after ack}
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 2'd0, 32'h0002_0100},
        {1'b1, 2'd1, 32'h0002_0130},
        {1'b1, 2'd2, 32'h0002_0130},
        {1'b0, 2'd0, 32'h0000_0030},
        {1'b1, 2'd3, 32'h0000_1030},
        {1'b0, 2'd1, 32'h0000_1000},
        {1'b0, 2'd3, 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_flush = 1'b0;
    logic [1:0]    req_part = '0;
    logic          ack;
    logic [W-1:0]  hr_ctrl;
    logic [W-1:0]  hr_stat;
    logic [W-1:0]  hold = '0;
    logic          glitch = 1'b0;
    logic          tog = 1'b0;
    int            checks = 0;
    int            errors = 0;
    int            acks = 0;
    int            cycles = 0;
    int            lat;

    mc_flush_ctrl #(.POLL_DELAY(D), .DEBOUNCE(DB)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_flush(req_flush),
        .req_part(req_part), .ack(ack), .hr_ctrl(hr_ctrl), .hr_stat(hr_stat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tog <= ~tog;
    always @(negedge clk) if (ack) acks <= acks + 1;
    assign hr_stat = (hr_ctrl & ~hold) | ((glitch && tog) ? 32'h4000_0000 : 32'h0);

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic fl, input logic [1:0] p);
        @(negedge clk);
        req_valid = 1'b1; req_flush = fl; req_part = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // counts falling edges after the request edge until ack is seen; checks pulse width (R8)
    task automatic wait_ack(input int limit, output int n);
        n = 1;
        while (!ack && n < limit) begin
            @(negedge clk);
            n++;
        end
        check("R8 ack seen", {31'b0, ack}, 32'd1);
        @(negedge clk);
        check("R8 ack one cycle", {31'b0, ack}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 ctrl at reset", hr_ctrl, 32'h0);
        check("R1 ack at reset", {31'b0, ack}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 drains, R6 empty list, R7 releases, R11 table layout
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][34], VEC[i][33:32]);
            wait_ack(4 * (D + DB + 8), lat);
            check($sformatf("R2/R7/R11 vector %0d ctrl", i), hr_ctrl, VEC[i][31:0]);
        end

        // R6: empty partition latency
        send(1'b1, 2'd2);
        wait_ack(50, lat);
        check("R6 empty latency ok", {31'b0, lat <= 3}, 32'd1);
        check("R6 empty ctrl unchanged", hr_ctrl, 32'h0);

        // R5: poll interval and debounce set the drain latency
        send(1'b1, 2'd3);
        wait_ack(500, lat);
        check("R5 drain latency", lat, D + DB + 4);
        send(1'b0, 2'd3);
        wait_ack(50, lat);

        // R3: stall on client 8, client 17 must not start
        hold = 32'h0000_0100;
        send(1'b1, 2'd0);
        acks = 0;
        repeat (3 * (D + DB + 4)) @(negedge clk);
        check("R3 only first client raised", hr_ctrl, 32'h0000_0100);
        check("R3 no ack while stalled", acks, 0);
        hold = '0;
        wait_ack(500, lat);
        check("R3 both clients after confirm", hr_ctrl, 32'h0002_0100);

        // R4: unstable status is never accepted
        glitch = 1'b1;
        send(1'b1, 2'd3);
        acks = 0;
        repeat (4 * (D + DB + 4)) @(negedge clk);
        check("R4 no ack while status unstable", acks, 0);
        check("R4 ctrl during rejects", hr_ctrl, 32'h0002_1100);
        glitch = 1'b0;
        wait_ack(500, lat);
        check("R4 accepted once stable", hr_ctrl, 32'h0002_1100);
        send(1'b0, 2'd3);
        wait_ack(50, lat);

        // R7: release ignores status
        send(1'b1, 2'd1);
        wait_ack(500, lat);
        check("R7 setup drain", hr_ctrl, 32'h0002_0130);
        hold = '1;
        send(1'b0, 2'd1);
        wait_ack(50, lat);
        check("R7 release latency", {31'b0, lat <= MAXC + 3}, 32'd1);
        check("R7 release keeps others", hr_ctrl, 32'h0002_0100);
        hold = '0;

        // R9: request while busy is ignored; R10: idle holds ctrl
        hold = 32'h0000_1000;
        send(1'b1, 2'd3);
        repeat (D) @(negedge clk);
        send(1'b0, 2'd0);
        hold = '0;
        wait_ack(500, lat);
        check("R9 busy request ignored", hr_ctrl, 32'h0002_1100);
        acks = 0;
        repeat (3 * (D + DB + 4)) @(negedge clk);
        check("R9 no second ack", acks, 0);
        check("R10 idle ctrl stable", hr_ctrl, 32'h0002_1100);

        // R1: reset in the middle of a drain
        hold = 32'h0000_0020;
        send(1'b1, 2'd1);
        repeat (D) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 ctrl cleared by reset", hr_ctrl, 32'h0);
        check("R1 ack low in reset", {31'b0, ack}, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule